// File: doc/BRIEF.md
# Dual-Slot SD Host Wrapper Register Block

This block is the 32-bit memory-mapped front end for a pair of SD host slot controllers. It decodes a 4 KiB address window. The lowest 256-byte page is its own global register space. The page at 0x100 belongs to slot 0 and the page at 0x200 belongs to slot 1. A request that lands in a slot page is passed straight through to that slot's port, and the slot's read data comes back on the shared response. The protocol engines inside the slots are not part of this block.

The global page holds several registers:
- an info word that reports which slots are present and accepts a soft-reset command;
- a debounce setting;
- bus, write-protect polarity and card-detect words, which are plain storage;
- writable shadow copies of each slot's capability word and maximum-current word, which are also driven out to the slots;
- an interrupt status word that mirrors each slot's interrupt level.

A single combined interrupt is raised from the interrupt status word. Every access receives a response one cycle after it is presented.

Top module: `sdhost_wrap_regs`

## Requirements
- R1: After reset the registers hold these values. The info word (offset 0x00) has bit 16 set, and bit 17 set too when NUM_SLOTS is 2. The debounce word (0x04) reads 0x00000005. Every other global word reads 0, except each slot's capability word, which reads CAP_INIT. `irq_out` and `slot_soft_rst` are low.
- R2: A request presented while `req_valid` is high at a clock edge gives `rsp_valid` high for exactly the following cycle. During that cycle `rsp_rdata` carries the read data, or 0 for a write.
- R3: Bit 0 of the info word is never stored and always reads 0. Bits 31..1 of a write to the info word are kept as written.
- R4: Writing the info word with bit 0 set drives `slot_soft_rst` high for exactly the one cycle after the write edge.
- R5: The capability and maximum-current words are mapped as follows: slot 0 at offsets 0x10 and 0x18, slot 1 at 0x20 and 0x28. They are writable, read back what was written, and appear on `slot_cap` and `slot_maxcur`, with slot n in bits [32n+31:32n].
- R6: Every other word in the global page is plain read/write storage, including bus 0x08, write-protect polarity 0xEC, card detect 0xF0 and the word at 0x14.
- R7: Bit n of the status word at 0xFC equals the level `slot_irq[n]` had at the previous clock edge. The upper bits read 0, and writes to 0xFC have no effect.
- R8: `irq_out` is the OR of the status bits of the present slots.
- R9: A full-word access at offsets (n+1)×0x100 to (n+1)×0x100+0xFF raises `slot_req_valid[n]` alone in the same cycle. It presents the page offset on `slot_addr`, and a read returns that slot's `slot_rdata` word. Global state is not touched.
- R10: An access at or above offset (NUM_SLOTS+1)×0x100 reads 0, changes nothing and strobes no slot.
- R11: An access whose byte enables are not 4'hF, or whose `req_addr[1:0]` is nonzero, reads 0, changes nothing and strobes no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte enables (only 4'hF is accepted) |
| req_addr | input | ADDR_W | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Response data |
| slot_req_valid | output | NUM_SLOTS | Per-slot access strobe |
| slot_req_write | output | 1 | Write flag toward the slots |
| slot_addr | output | 8 | Byte offset within the slot page |
| slot_wdata | output | 32 | Write data toward the slots |
| slot_rdata | input | NUM_SLOTS*32 | Read data from each slot |
| slot_soft_rst | output | 1 | One-cycle soft-reset pulse toward the slots |
| slot_cap | output | NUM_SLOTS*32 | Capability shadow words |
| slot_maxcur | output | NUM_SLOTS*32 | Maximum-current shadow words |
| slot_irq | input | NUM_SLOTS | Interrupt level from each slot |
| irq_out | output | 1 | Combined interrupt |

## Verification
Register accesses are tried with several kinds of input pattern:
- Distinct data patterns are written to the aliased offsets and to the neighbouring plain words. This tells whether the shadow copies are kept apart from the backing storage.
- Slot-page offsets that coincide with global alias offsets are accessed. This tells routing apart from global decoding.
- Accesses are made above the last slot page, with partial byte enables, and with misaligned addresses. These tell true rejection apart from a silently aliased write.

The interrupt inputs are stepped through every combination of levels, and status writes are interleaved. This tells a live mirror apart from a stored register.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned PAGE_LSB   = 8;
    localparam int unsigned PAGE_WORDS = 64;
    localparam int unsigned IDX_W      = $clog2(PAGE_WORDS);

    // word indices inside the global page (byte offset / 4)
    localparam logic [IDX_W-1:0] W_INFO     = 6'h00;
    localparam logic [IDX_W-1:0] W_DEBOUNCE = 6'h01;
    localparam logic [IDX_W-1:0] W_CAP0     = 6'h04;
    localparam logic [IDX_W-1:0] W_MCUR0    = 6'h06;
    localparam logic [IDX_W-1:0] W_IRQSTAT  = 6'h3F;
    localparam int unsigned      ALIAS_STEP = 4;

    localparam int unsigned INFO_SRST_BIT = 0;
    localparam int unsigned INFO_PRES_LSB = 16;
    localparam logic [DATA_W-1:0] DEBOUNCE_INIT = 32'h0000_0005;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_GLOBAL,
        ACC_SLOT,
        ACC_VOID
    } acc_kind_e;
endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
    import sdw_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SLOT_W    = 1
) (
    input  logic              req_valid,
    input  logic [3:0]        req_be,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_kind_e         kind,
    output logic [SLOT_W-1:0] slot_sel,
    output logic [IDX_W-1:0]  word_idx
);
    localparam int unsigned PG_W = ADDR_W - PAGE_LSB;

    logic [PG_W-1:0] page;
    logic            aligned;

    assign page     = req_addr[ADDR_W-1:PAGE_LSB];
    assign word_idx = req_addr[PAGE_LSB-1:2];
    assign aligned  = (req_addr[1:0] == 2'b00);

    always_comb begin
        kind     = ACC_IDLE;
        slot_sel = '0;
        if (req_valid) begin
            if (req_be != 4'hF || !aligned) begin
                kind = ACC_VOID;
            end else if (page == '0) begin
                kind = ACC_GLOBAL;
            end else if (page <= PG_W'(NUM_SLOTS)) begin
                kind     = ACC_SLOT;
                slot_sel = SLOT_W'(page - PG_W'(1));
            end else begin
                kind = ACC_VOID;
            end
        end
    end
endmodule

// File: rtl/sdw_slot_route.sv
module sdw_slot_route
    import sdw_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned SLOT_W    = 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  acc_kind_e                   kind,
    input  logic [SLOT_W-1:0]           slot_sel,
    input  logic [NUM_SLOTS*DATA_W-1:0] slot_rdata,
    output logic [NUM_SLOTS-1:0]        slot_req_valid,
    output logic [DATA_W-1:0]           sel_rdata
);
    logic [NUM_SLOTS-1:0][DATA_W-1:0] rd_words;

    assign rd_words = slot_rdata;

    for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_strobe
        assign slot_req_valid[n] = (kind == ACC_SLOT) && (slot_sel == SLOT_W'(n));
    end

    always_comb begin
        sel_rdata = '0;
        for (int n = 0; n < NUM_SLOTS; n++) begin
            if (slot_sel == SLOT_W'(n)) sel_rdata = rd_words[n];
        end
    end

    // R9: at most one slot strobed per access
    p_one_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_req_valid));

    // R10 / R11: rejected accesses never reach a slot
    p_void_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_VOID) |-> (slot_req_valid == '0));
endmodule

// File: rtl/sdw_glob_regs.sv
module sdw_glob_regs
    import sdw_pkg::*;
#(
    parameter int unsigned    NUM_SLOTS = 2,
    parameter logic [31:0]    CAP_INIT  = 32'h01E8_0C80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            word_idx,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NUM_SLOTS-1:0]        slot_irq,
    output logic [DATA_W-1:0]           rdata,
    output logic [NUM_SLOTS*DATA_W-1:0] cap_words,
    output logic [NUM_SLOTS*DATA_W-1:0] mcur_words,
    output logic                        irq_any,
    output logic                        soft_rst
);
    localparam logic [DATA_W-1:0] INFO_INIT =
        DATA_W'(((1 << NUM_SLOTS) - 1) << INFO_PRES_LSB);
    localparam logic [DATA_W-1:0] SRST_MASK = DATA_W'(1) << INFO_SRST_BIT;

    typedef struct packed {
        logic [PAGE_WORDS-1:0][DATA_W-1:0] words;
        logic [NUM_SLOTS-1:0][DATA_W-1:0]  cap;
        logic [NUM_SLOTS-1:0][DATA_W-1:0]  mcur;
        logic [NUM_SLOTS-1:0]              irq;
        logic                              srst;
    } glob_st_t;

    glob_st_t st_d, st_q;
    logic     alias_hit;

    function automatic logic [IDX_W-1:0] cap_idx(input int n);
        return W_CAP0 + IDX_W'(ALIAS_STEP * n);
    endfunction

    function automatic logic [IDX_W-1:0] mcur_idx(input int n);
        return W_MCUR0 + IDX_W'(ALIAS_STEP * n);
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.srst = 1'b0;
        st_d.irq  = slot_irq;
        alias_hit = 1'b0;
        if (wr_en) begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                if (word_idx == cap_idx(n)) begin
                    st_d.cap[n] = wdata;
                    alias_hit   = 1'b1;
                end
                if (word_idx == mcur_idx(n)) begin
                    st_d.mcur[n] = wdata;
                    alias_hit    = 1'b1;
                end
            end
            if (word_idx == W_INFO) begin
                st_d.words[W_INFO] = wdata & ~SRST_MASK;
                st_d.srst          = wdata[INFO_SRST_BIT];
            end else if (word_idx != W_IRQSTAT && !alias_hit) begin
                st_d.words[word_idx] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q                   <= '0;
            st_q.words[W_INFO]     <= INFO_INIT;
            st_q.words[W_DEBOUNCE] <= DEBOUNCE_INIT;
            for (int n = 0; n < NUM_SLOTS; n++) st_q.cap[n] <= CAP_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = st_q.words[word_idx];
        if (word_idx == W_IRQSTAT) rdata = DATA_W'(st_q.irq);
        for (int n = 0; n < NUM_SLOTS; n++) begin
            if (word_idx == cap_idx(n))  rdata = st_q.cap[n];
            if (word_idx == mcur_idx(n)) rdata = st_q.mcur[n];
        end
    end

    assign cap_words  = st_q.cap;
    assign mcur_words = st_q.mcur;
    assign irq_any    = |st_q.irq;
    assign soft_rst   = st_q.srst;

    // R4: a pulse only follows a write of the info word with bit 0 set
    p_srst_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |-> $past(wr_en && word_idx == W_INFO && wdata[INFO_SRST_BIT]));

    // R7: status bits track the slot levels one edge later
    p_irq_mirror_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.irq == $past(slot_irq)));
endmodule

// File: rtl/sdhost_wrap_regs.sv
module sdhost_wrap_regs
    import sdw_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 2,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [31:0] CAP_INIT  = 32'h01E8_0C80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [3:0]                  req_be,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [31:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic [31:0]                 rsp_rdata,
    output logic [NUM_SLOTS-1:0]        slot_req_valid,
    output logic                        slot_req_write,
    output logic [7:0]                  slot_addr,
    output logic [31:0]                 slot_wdata,
    input  logic [NUM_SLOTS*32-1:0]     slot_rdata,
    output logic                        slot_soft_rst,
    output logic [NUM_SLOTS*32-1:0]     slot_cap,
    output logic [NUM_SLOTS*32-1:0]     slot_maxcur,
    input  logic [NUM_SLOTS-1:0]        slot_irq,
    output logic                        irq_out
);
    localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rsp_st_t;

    acc_kind_e         kind;
    logic [SLOT_W-1:0] slot_sel;
    logic [IDX_W-1:0]  word_idx;
    logic [DATA_W-1:0] glob_rdata;
    logic [DATA_W-1:0] sel_rdata;
    logic              glob_wr;
    rsp_st_t           rsp_d, rsp_q;

    sdw_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W),
        .SLOT_W    (SLOT_W)
    ) u_decode (
        .req_valid (req_valid),
        .req_be    (req_be),
        .req_addr  (req_addr),
        .kind      (kind),
        .slot_sel  (slot_sel),
        .word_idx  (word_idx)
    );

    assign glob_wr = (kind == ACC_GLOBAL) && req_write;

    sdw_glob_regs #(
        .NUM_SLOTS (NUM_SLOTS),
        .CAP_INIT  (CAP_INIT)
    ) u_glob (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (glob_wr),
        .word_idx   (word_idx),
        .wdata      (req_wdata),
        .slot_irq   (slot_irq),
        .rdata      (glob_rdata),
        .cap_words  (slot_cap),
        .mcur_words (slot_maxcur),
        .irq_any    (irq_out),
        .soft_rst   (slot_soft_rst)
    );

    sdw_slot_route #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_route (
        .clk            (clk),
        .rst_n          (rst_n),
        .kind           (kind),
        .slot_sel       (slot_sel),
        .slot_rdata     (slot_rdata),
        .slot_req_valid (slot_req_valid),
        .sel_rdata      (sel_rdata)
    );

    assign slot_req_write = req_write;
    assign slot_addr      = req_addr[PAGE_LSB-1:0];
    assign slot_wdata     = req_wdata;

    always_comb begin
        rsp_d.valid = req_valid;
        rsp_d.data  = '0;
        if (!req_write) begin
            case (kind)
                ACC_GLOBAL: rsp_d.data = glob_rdata;
                ACC_SLOT:   rsp_d.data = sel_rdata;
                default:    rsp_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;

    // R2: one response per request, one cycle later
    p_rsp_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));

    // R8: combined interrupt only after some slot level was high
    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> $past(|slot_irq));
endmodule

// File: tb/sdhost_wrap_regs_tb.sv
`timescale 1ns/1ps
module sdhost_wrap_regs_tb;
    localparam int          NS  = 2;
    localparam logic [31:0] CAP = 32'h01E8_0C80;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]        req_be = 4'h0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NS-1:0]     slot_req_valid;
    logic              slot_req_write;
    logic [7:0]        slot_addr;
    logic [31:0]       slot_wdata;
    logic [NS*32-1:0]  slot_rdata;
    logic              slot_soft_rst;
    logic [NS*32-1:0]  slot_cap, slot_maxcur;
    logic [NS-1:0]     slot_irq = '0;
    logic              irq_out;

    int total = 0, bad = 0;
    bit done = 0;
    string cur_tag = "R2";

    always #4 clk = ~clk;

    sdhost_wrap_regs #(.NUM_SLOTS(NS), .ADDR_W(12), .CAP_INIT(CAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .slot_req_valid(slot_req_valid), .slot_req_write(slot_req_write),
        .slot_addr(slot_addr), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata),
        .slot_soft_rst(slot_soft_rst), .slot_cap(slot_cap),
        .slot_maxcur(slot_maxcur), .slot_irq(slot_irq), .irq_out(irq_out)
    );

    function automatic logic [31:0] slot_val(input int n, input logic [7:0] a);
        return 32'hC0DE_0000 | (32'(n) << 12) | 32'(a);
    endfunction

    always_comb begin
        for (int n = 0; n < NS; n++) slot_rdata[n*32 +: 32] = slot_val(n, slot_addr);
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_mem [64];
    logic [31:0] m_cap [NS];
    logic [31:0] m_mcur[NS];
    logic [NS-1:0] m_stat;
    logic        m_rsp_v, m_srst;
    logic [31:0] m_rsp_d;
    string       m_tag;

    function automatic logic [31:0] m_read(input int w);
        if (w == 63) return 32'(m_stat);
        for (int n = 0; n < NS; n++) begin
            if (w == 4 + 4*n) return m_cap[n];
            if (w == 6 + 4*n) return m_mcur[n];
        end
        return m_mem[w];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m_mem[i] = 32'h0;
            m_mem[0] = 32'h0003_0000;
            m_mem[1] = 32'h5;
            for (int n = 0; n < NS; n++) begin m_cap[n] = CAP; m_mcur[n] = 0; end
            m_stat = '0; m_rsp_v = 0; m_rsp_d = 0; m_srst = 0; m_tag = "R1";
        end else begin
            int page, w;
            bit hit;
            m_rsp_v = req_valid; m_rsp_d = 0; m_srst = 0; m_tag = cur_tag;
            page = int'(req_addr[11:8]); w = int'(req_addr[7:2]);
            if (req_valid && req_be == 4'hF && req_addr[1:0] == 2'b00) begin
                if (page == 0) begin
                    if (!req_write) m_rsp_d = m_read(w);
                    else if (w == 0) begin
                        m_mem[0] = req_wdata & 32'hFFFF_FFFE; m_srst = req_wdata[0];
                    end else if (w != 63) begin
                        hit = 0;
                        for (int n = 0; n < NS; n++) begin
                            if (w == 4 + 4*n) begin m_cap[n] = req_wdata; hit = 1; end
                            if (w == 6 + 4*n) begin m_mcur[n] = req_wdata; hit = 1; end
                        end
                        if (!hit) m_mem[w] = req_wdata;
                    end
                end else if (page <= NS && !req_write) begin
                    m_rsp_d = slot_val(page - 1, req_addr[7:0]);
                end
            end
            m_stat = slot_irq;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rsp_valid === m_rsp_v, "R2", 32'(rsp_valid), 32'(m_rsp_v));
            if (m_rsp_v) chk(rsp_rdata === m_rsp_d, m_tag, rsp_rdata, m_rsp_d);
            chk(irq_out === (|m_stat), "R8", 32'(irq_out), 32'(|m_stat));
            chk(slot_soft_rst === m_srst, "R4", 32'(slot_soft_rst), 32'(m_srst));
            for (int n = 0; n < NS; n++) begin
                chk(slot_cap[n*32 +: 32] === m_cap[n], "R5", slot_cap[n*32 +: 32], m_cap[n]);
                chk(slot_maxcur[n*32 +: 32] === m_mcur[n], "R5",
                    slot_maxcur[n*32 +: 32], m_mcur[n]);
            end
        end
    end

    task automatic acc(input logic wr, input logic [3:0] be, input logic [11:0] a,
                       input logic [31:0] d, input string tag, output logic [31:0] rd);
        logic [NS-1:0] exp_sv;
        int pg;
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
        #1;
        pg = int'(a[11:8]);
        exp_sv = '0;
        if (be == 4'hF && a[1:0] == 2'b00 && pg >= 1 && pg <= NS) exp_sv[pg-1] = 1'b1;
        chk(slot_req_valid === exp_sv, tag, 32'(slot_req_valid), 32'(exp_sv));
        if (exp_sv != 0) begin
            chk(slot_addr === a[7:0], "R9", 32'(slot_addr), 32'(a[7:0]));
            chk(slot_req_write === wr, "R9", 32'(slot_req_write), 32'(wr));
        end
        @(negedge clk);
        req_valid = 0;
        rd = rsp_rdata;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        acc(1'b0, 4'hF, a, 32'h0, tag, v);
        chk(v === e, tag, v, e);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        logic [31:0] v;
        acc(1'b1, 4'hF, a, d, tag, v);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset values
        chk(irq_out === 1'b0, "R1", 32'(irq_out), 32'h0);
        chk(slot_soft_rst === 1'b0, "R1", 32'(slot_soft_rst), 32'h0);
        rd_exp(12'h000, 32'h0003_0000, "R1");
        rd_exp(12'h004, 32'h0000_0005, "R1");
        rd_exp(12'h008, 32'h0, "R1");
        rd_exp(12'h010, CAP, "R1");
        rd_exp(12'h020, CAP, "R1");
        rd_exp(12'h018, 32'h0, "R1");
        rd_exp(12'h0FC, 32'h0, "R1");

        // R3 / R4 info write with reset request
        @(negedge clk); cur_tag = "R4";
        req_valid = 1; req_write = 1; req_be = 4'hF; req_addr = 12'h000;
        req_wdata = 32'hA5A5_0003;
        @(negedge clk); req_valid = 0;
        chk(slot_soft_rst === 1'b1, "R4", 32'(slot_soft_rst), 32'h1);
        @(negedge clk);
        chk(slot_soft_rst === 1'b0, "R4", 32'(slot_soft_rst), 32'h0);
        rd_exp(12'h000, 32'hA5A5_0002, "R3");
        wr(12'h000, 32'h0003_0000, "R3");
        rd_exp(12'h000, 32'h0003_0000, "R3");

        // R5 aliases, R6 plain neighbour
        wr(12'h010, 32'h1111_0001, "R5");
        wr(12'h018, 32'h0000_0022, "R5");
        wr(12'h020, 32'h3333_0003, "R5");
        wr(12'h028, 32'h0000_0044, "R5");
        wr(12'h014, 32'h5A5A_1414, "R6");
        rd_exp(12'h010, 32'h1111_0001, "R5");
        rd_exp(12'h018, 32'h0000_0022, "R5");
        rd_exp(12'h020, 32'h3333_0003, "R5");
        rd_exp(12'h028, 32'h0000_0044, "R5");
        rd_exp(12'h014, 32'h5A5A_1414, "R6");
        chk(slot_cap[63:32] === 32'h3333_0003, "R5", slot_cap[63:32], 32'h3333_0003);

        // R6 plain storage
        wr(12'h008, 32'hDEAD_0008, "R6");
        wr(12'h0EC, 32'h0000_0003, "R6");
        wr(12'h0F0, 32'hFFFF_FFFF, "R6");
        rd_exp(12'h008, 32'hDEAD_0008, "R6");
        rd_exp(12'h0EC, 32'h0000_0003, "R6");
        rd_exp(12'h0F0, 32'hFFFF_FFFF, "R6");

        // R7 / R8 interrupt mirror
        for (int p = 0; p < 4; p++) begin
            @(negedge clk); slot_irq = 2'(p);
            @(negedge clk);
            chk(irq_out === (p != 0), "R8", 32'(irq_out), 32'(p != 0));
            rd_exp(12'h0FC, 32'(p), "R7");
        end
        wr(12'h0FC, 32'hFFFF_FFFF, "R7");
        @(negedge clk); slot_irq = 2'b00;
        @(negedge clk);
        rd_exp(12'h0FC, 32'h0, "R7");

        // R9 slot routing
        rd_exp(12'h104, slot_val(0, 8'h04), "R9");
        rd_exp(12'h2F8, slot_val(1, 8'hF8), "R9");
        wr(12'h110, 32'h9999_9999, "R9");
        wr(12'h228, 32'h8888_8888, "R9");
        rd_exp(12'h010, 32'h1111_0001, "R9");
        rd_exp(12'h028, 32'h0000_0044, "R9");

        // R10 beyond the slot pages
        wr(12'h308, 32'h7777_7777, "R10");
        rd_exp(12'h308, 32'h0, "R10");
        rd_exp(12'hFFC, 32'h0, "R10");
        rd_exp(12'h008, 32'hDEAD_0008, "R10");

        // R11 partial enables and misaligned offsets
        acc(1'b1, 4'h3, 12'h008, 32'h1234_5678, "R11", v);
        acc(1'b1, 4'hF, 12'h00A, 32'h1234_5678, "R11", v);
        rd_exp(12'h008, 32'hDEAD_0008, "R11");
        acc(1'b0, 4'h1, 12'h004, 32'h0, "R11", v);
        chk(v === 32'h0, "R11", v, 32'h0);
        acc(1'b0, 4'hC, 12'h104, 32'h0, "R11", v);
        chk(v === 32'h0, "R11", v, 32'h0);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule